// File: doc/BRIEF.md
# Thermostat Alarm with Fault Filtering

This block sits behind a temperature converter. Each time a new sample arrives it compares the sample against an upper trip limit and a lower trip limit, and it drives a single alarm line. A filter counts consecutive out-of-limit samples and asserts the alarm only after a programmed run length.

In comparator mode the alarm acts as a thermostat with hysteresis. In interrupt mode the alarm takes turns between an over-limit event and an under-limit event. Each event is held until the host acknowledges it with a register read or by entering shutdown. A configuration byte sets the compare resolution, the run length, the output polarity, the mode and shutdown. The block does not include the converter or the serial bus.

Top module: `thermo_alarm`

## Requirements
- R1: After reset the block is idle in comparator mode, watching the upper limit with an empty run counter. With cfg_i = 0 the alarm output is high (inactive, active-low).
- R2: Configuration bits [4:3] set the run length needed to assert: 00 = 1, 01 = 2, 10 = 4, 11 = 6 consecutive qualifying samples.
- R3: The run counter returns to zero on any accepted sample that fails the condition being watched. It holds its value in cycles with no sample and a stable configuration.
- R4: In comparator mode (bit 1 = 0) the alarm asserts on the sample that completes the run above the upper limit. It stays active until the first sample below the lower limit; that sample alone releases it, and watching the upper limit starts again.
- R5: Both compares are strict. A sample equal to the upper limit does not qualify, and a sample equal to the lower limit does not release or qualify.
- R6: In interrupt mode (bit 1 = 1) a completed run above the upper limit asserts the alarm, and a register-read strobe clears it. The block then needs a full run below the lower limit to assert again. After the next clear it returns to watching the upper limit. While the alarm is set, samples are ignored.
- R7: Shutdown (bit 0 = 1) clears a set interrupt-mode alarm in the same way a read does. While shutdown is 1, sample strobes are ignored in both modes, and a comparator-mode alarm holds its state.
- R8: A read strobe has no effect in comparator mode. In interrupt mode it has no effect while no alarm is set.
- R9: Bit 2 selects the output level. With bit 2 = 0 the alarm output is driven low when active. With bit 2 = 1 it is driven high when active. A change of bit 2 takes effect in the same cycle.
- R10: Bits [6:5] select how many upper bits of the 16-bit sample and of both limits are compared: 00 = 9 bits (15:7), 01 = 10, 10 = 11, 11 = 12 bits (15:4). Lower bits are ignored.
- R11: Sample and limits are compared as signed two's complement values.
- R12: A change of the mode bit clears the run counter and returns the block to inactive, watching the upper limit, on the next clock edge.
- R13: With no sample strobe, no read strobe, no shutdown and a stable configuration, the alarm output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | New temperature sample present this cycle |
| sample_i | input | 16 | Temperature sample, two's complement, left-aligned |
| trip_hi_i | input | 16 | Upper trip limit, same format as the sample |
| trip_lo_i | input | 16 | Lower (hysteresis) limit, same format as the sample |
| cfg_i | input | 8 | Bit 0 shutdown, bit 1 interrupt mode, bit 2 polarity, bits [4:3] run length, bits [6:5] resolution |
| reg_read_i | input | 1 | One-cycle strobe for any host register read |
| alarm_o | output | 1 | Alarm level, polarity set by cfg_i bit 2 |

## Verification
The bound assertions check on every cycle that the output and the run counter stay still when nothing can move them. They also check that a read or shutdown always clears a set interrupt-mode alarm, and that the counter never climbs past the largest run length. The bench scenarios cover the rest: run lengths for each setting, strict-boundary samples, the alternating interrupt sequence, the effect of resolution on limits with low-order bits, negative limits and mode switches while active. A behavioural reference model, compared on every clock, confirms each of these, and a long random stretch mixes all settings.

// File: rtl/thermo_alarm_pkg.sv
package thermo_alarm_pkg;
  localparam int unsigned CFG_SD     = 0;
  localparam int unsigned CFG_INTR   = 1;
  localparam int unsigned CFG_POL    = 2;
  localparam int unsigned CFG_FLT_LO = 3;
  localparam int unsigned CFG_RES_LO = 5;
  localparam int unsigned CNT_W      = 3;

  typedef enum logic [1:0] {
    PH_WATCH_HI = 2'd0,
    PH_HI_SET   = 2'd1,
    PH_WATCH_LO = 2'd2,
    PH_LO_SET   = 2'd3
  } phase_e;

  function automatic logic [CNT_W-1:0] need_of(input logic [1:0] f);
    case (f)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(2);
      2'd2:    return CNT_W'(4);
      default: return CNT_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/thermo_res_mask.sv
module thermo_res_mask #(
  parameter int unsigned TW       = 16,
  parameter int unsigned MIN_BITS = 9
) (
  input  logic [1:0]    res_i,
  input  logic [TW-1:0] val_i,
  output logic [TW-1:0] val_o
);
  // lowest kept bit at coarsest resolution
  localparam int KEEP_LO = int'(TW) - int'(MIN_BITS);

  generate
    for (genvar i = 0; i < int'(TW); i++) begin : g_bit
      assign val_o[i] = ((i + int'(res_i)) >= KEEP_LO) ? val_i[i] : 1'b0;
    end
  endgenerate
endmodule

// File: rtl/thermo_fault_filter.sv
module thermo_fault_filter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             fire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign fire_o  = step_i & hit_i & (cnt_nxt >= {1'b0, need_i});
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      if (hit_i && !fire_o) cnt_q <= cnt_nxt[CNT_W-1:0];
      else                  cnt_q <= '0;
    end
  end
endmodule

// File: rtl/thermo_alarm_fsm.sv
module thermo_alarm_fsm
  import thermo_alarm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic intr_i,
  input  logic mode_chg_i,
  input  logic clr_req_i,
  input  logic samp_ok_i,
  input  logic below_i,
  input  logic fire_i,
  output logic watching_o,
  output logic watch_hi_o,
  output logic active_o,
  output logic flt_clr_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (mode_chg_i) begin
      phase_d = PH_WATCH_HI;
    end else begin
      case (phase_q)
        PH_WATCH_HI: if (fire_i) phase_d = PH_HI_SET;
        PH_HI_SET: begin
          if (intr_i) begin
            if (clr_req_i) phase_d = PH_WATCH_LO;
          end else if (samp_ok_i && below_i) begin
            phase_d = PH_WATCH_HI;
          end
        end
        PH_WATCH_LO: if (fire_i) phase_d = PH_LO_SET;
        PH_LO_SET:   if (clr_req_i) phase_d = PH_WATCH_HI;
        default:     phase_d = PH_WATCH_HI;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_WATCH_HI;
    else         phase_q <= phase_d;
  end

  assign watch_hi_o = (phase_q == PH_WATCH_HI);
  assign watching_o = (phase_q == PH_WATCH_HI) || (phase_q == PH_WATCH_LO);
  assign active_o   = (phase_q == PH_HI_SET) || (phase_q == PH_LO_SET);
  assign flt_clr_o  = mode_chg_i | (intr_i & clr_req_i & active_o);
endmodule

// File: rtl/thermo_alarm.sv
module thermo_alarm
  import thermo_alarm_pkg::*;
#(
  parameter int unsigned TW       = 16,
  parameter int unsigned MIN_BITS = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_valid_i,
  input  logic [TW-1:0] sample_i,
  input  logic [TW-1:0] trip_hi_i,
  input  logic [TW-1:0] trip_lo_i,
  input  logic [7:0]    cfg_i,
  input  logic          reg_read_i,
  output logic          alarm_o
);
  localparam int unsigned NOPS = 3;

  logic [NOPS-1:0][TW-1:0] raw, kept;
  logic [1:0]       res;
  logic             sd, intr, pol, mode_q, mode_chg;
  logic             samp_ok, clr_req, above, below, hit;
  logic             watching, watch_hi, active, flt_clr, fire;
  logic [CNT_W-1:0] fault_need, fault_cnt;

  assign res  = cfg_i[CFG_RES_LO +: 2];
  assign sd   = cfg_i[CFG_SD];
  assign intr = cfg_i[CFG_INTR];
  assign pol  = cfg_i[CFG_POL];
  assign fault_need = need_of(cfg_i[CFG_FLT_LO +: 2]);

  assign raw[0] = sample_i;
  assign raw[1] = trip_hi_i;
  assign raw[2] = trip_lo_i;

  generate
    for (genvar k = 0; k < int'(NOPS); k++) begin : g_mask
      thermo_res_mask #(.TW(TW), .MIN_BITS(MIN_BITS)) u_mask (
        .res_i (res),
        .val_i (raw[k]),
        .val_o (kept[k])
      );
    end
  endgenerate

  assign above = $signed(kept[0]) > $signed(kept[1]);
  assign below = $signed(kept[0]) < $signed(kept[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= intr;
  end

  assign mode_chg = intr ^ mode_q;
  assign samp_ok  = sample_valid_i & ~sd;
  assign clr_req  = reg_read_i | sd;

  thermo_alarm_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .intr_i     (intr),
    .mode_chg_i (mode_chg),
    .clr_req_i  (clr_req),
    .samp_ok_i  (samp_ok),
    .below_i    (below),
    .fire_i     (fire),
    .watching_o (watching),
    .watch_hi_o (watch_hi),
    .active_o   (active),
    .flt_clr_o  (flt_clr)
  );

  assign hit = watch_hi ? above : below;

  thermo_fault_filter #(.CNT_W(CNT_W)) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (flt_clr),
    .step_i (samp_ok & watching),
    .hit_i  (hit),
    .need_i (fault_need),
    .fire_o (fire),
    .cnt_o  (fault_cnt)
  );

  assign alarm_o = pol ? active : ~active;
endmodule

// File: rtl/thermo_alarm_chk.sv
module thermo_alarm_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_valid_i,
  input logic [7:0]       cfg_i,
  input logic             reg_read_i,
  input logic             alarm_o,
  input logic [CNT_W-1:0] fault_cnt
);
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_valid_i && !reg_read_i && !cfg_i[0] && $stable(cfg_i))
      |=> ($stable(cfg_i) -> $stable(alarm_o))); // R13

  AST_INTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[1] && $stable(cfg_i) && (reg_read_i || cfg_i[0]) && (alarm_o == cfg_i[2]))
      |=> ($stable(cfg_i) -> (alarm_o != cfg_i[2]))); // R6

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_cnt <= CNT_W'(5)); // R2

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_valid_i && $stable(cfg_i)) |=> $stable(fault_cnt)); // R3
endmodule

bind thermo_alarm thermo_alarm_chk #(.CNT_W(thermo_alarm_pkg::CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .cfg_i          (cfg_i),
  .reg_read_i     (reg_read_i),
  .alarm_o        (alarm_o),
  .fault_cnt      (fault_cnt)
);

// File: tb/thermo_alarm_bench.sv
`timescale 1ns/1ps
module thermo_alarm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sv = 1'b0;
  logic [15:0] smp = '0, hi = 16'h5000, lo = 16'h4B00;
  logic [7:0]  cfg = '0;
  logic        rd = 1'b0;
  logic        alarm;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  thermo_alarm u_thermo_alarm (
    .clk_i (clk), .rst_ni (rst_n), .sample_valid_i (sv), .sample_i (smp),
    .trip_hi_i (hi), .trip_lo_i (lo), .cfg_i (cfg), .reg_read_i (rd),
    .alarm_o (alarm)
  );

  // reference model: 0 idle-high, 1 high set, 2 idle-low, 3 low set
  int m_state = 0, m_cnt = 0;
  bit m_prev_mode = 0;

  function automatic int qv(input logic [15:0] v, input int bits);
    logic signed [15:0] s;
    s = v;
    return int'(s >>> (16 - bits));
  endfunction

  function automatic int need_len(input logic [1:0] f);
    case (f) 2'd0: return 1; 2'd1: return 2; 2'd2: return 4; default: return 6; endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_prev_mode = 0;
    end else begin
      int bits, need, s, h, l;
      bit md, sd;
      bits = 9 + int'(cfg[6:5]);
      need = need_len(cfg[4:3]);
      md = cfg[1]; sd = cfg[0];
      s = qv(smp, bits); h = qv(hi, bits); l = qv(lo, bits);
      if (md != m_prev_mode) begin
        m_state = 0; m_cnt = 0;
      end else if (md && (m_state == 1 || m_state == 3) && (rd || sd)) begin
        m_state = (m_state == 1) ? 2 : 0; m_cnt = 0;
      end else if (sv && !sd) begin
        if (m_state == 0 || m_state == 2) begin
          if ((m_state == 0) ? (s > h) : (s < l)) begin
            m_cnt++;
            if (m_cnt >= need) begin m_state++; m_cnt = 0; end
          end else m_cnt = 0;
        end else if (!md && m_state == 1 && s < l) begin
          m_state = 0;
        end
      end
      m_prev_mode = md;
    end
  end

  function automatic bit exp_out();
    bit act;
    act = (m_state == 1 || m_state == 3);
    return cfg[2] ? act : !act;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (alarm !== exp_out()) begin
        n_bad++;
        $display("FAIL %s: alarm_o=%0b expected %0b at %0t", cur_req, alarm, exp_out(), $time);
      end
    end
  end

  function automatic logic [7:0] mk(bit sd, bit intr, bit pol, logic [1:0] f, logic [1:0] r);
    return {1'b0, r, f, pol, intr, sd};
  endfunction

  task automatic put(input logic [15:0] t);
    @(negedge clk); #1; sv = 1'b1; smp = t; rd = 1'b0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; sv = 1'b0; rd = 1'b0; end
  endtask
  task automatic rdx();
    @(negedge clk); #1; sv = 1'b0; rd = 1'b1;
  endtask
  task automatic setcfg(input logic [7:0] c);
    @(negedge clk); #1; cfg = c; sv = 1'b0; rd = 1'b0;
  endtask
  task automatic expect_out(input bit e, input string r);
    n_cmp++;
    if (alarm !== e) begin
      n_bad++;
      $display("FAIL %s: alarm_o=%0b expected %0b (fixed)", r, alarm, e);
    end
  endtask
  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog: run did not finish");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    cur_req = "R1"; expect_out(1'b1, "R1");

    // comparator, run length 1
    cur_req = "R4";
    put(16'h5100); idle(1); expect_out(1'b0, "R4");
    put(16'h4C00); put(16'h4B80); idle(2);
    cur_req = "R5";
    put(16'h4B00); idle(1); expect_out(1'b0, "R5");
    cur_req = "R4";
    put(16'h4A00); idle(1); expect_out(1'b1, "R4");
    cur_req = "R5";
    put(16'h5000); put(16'h5000); idle(1); expect_out(1'b1, "R5");

    cur_req = "R8";
    rdx(); rdx(); idle(2);
    put(16'h6000); rdx(); idle(2); expect_out(1'b0, "R8");
    put(16'h0000); idle(1);

    cur_req = "R13";
    idle(6);

    // run lengths with interruptions
    for (int f = 1; f < 4; f++) begin
      cur_req = "R2";
      setcfg(mk(0, 0, 0, 2'(f), 2'd0));
      for (int j = 0; j < need_len(2'(f)) - 1; j++) put(16'h5200);
      cur_req = "R3";
      put(16'h4E00);
      idle(3);
      cur_req = "R2";
      for (int j = 0; j < need_len(2'(f)); j++) put(16'h5200);
      idle(1); expect_out(1'b0, "R2");
      put(16'h3000); idle(2);
    end

    // interrupt mode, run length 2
    cur_req = "R12";
    setcfg(mk(0, 1, 0, 2'd1, 2'd0)); idle(2);
    cur_req = "R6";
    put(16'h5800); put(16'h5800); idle(1); expect_out(1'b0, "R6");
    put(16'h3000); put(16'h3000); idle(1);
    rdx(); idle(1); expect_out(1'b1, "R6");
    put(16'h5800); put(16'h5800); put(16'h5800); idle(1);
    cur_req = "R8";
    rdx(); idle(1);
    cur_req = "R6";
    put(16'h4000); put(16'h4000); idle(1); expect_out(1'b0, "R6");
    rdx(); put(16'h6000); put(16'h6000); idle(1);
    rdx(); idle(2);

    cur_req = "R7";
    put(16'h6000); put(16'h6000); idle(1);
    setcfg(mk(1, 1, 0, 2'd1, 2'd0)); idle(1); expect_out(1'b1, "R7");
    put(16'h3000); put(16'h3000); put(16'h3000); idle(1);
    setcfg(mk(0, 1, 0, 2'd1, 2'd0)); idle(2);
    put(16'h3000); put(16'h3000); idle(1);
    rdx(); idle(1);
    setcfg(mk(0, 0, 0, 2'd0, 2'd0)); put(16'h6000); idle(1);
    setcfg(mk(1, 0, 0, 2'd0, 2'd0)); put(16'h1000); put(16'h1000); idle(2);
    expect_out(1'b0, "R7");
    setcfg(mk(0, 0, 0, 2'd0, 2'd0)); put(16'h1000); idle(1);

    cur_req = "R9";
    setcfg(mk(0, 0, 1, 2'd0, 2'd0)); idle(1); expect_out(1'b0, "R9");
    put(16'h6000); idle(1); expect_out(1'b1, "R9");
    setcfg(mk(0, 0, 0, 2'd0, 2'd0)); idle(1); expect_out(1'b0, "R9");
    put(16'h1000); idle(1);

    cur_req = "R10";
    hi = 16'h5080; lo = 16'h4B70;
    for (int r = 0; r < 4; r++) begin
      setcfg(mk(0, 0, 0, 2'd0, 2'(r)));
      put(16'h5040); put(16'h50F0); put(16'h508F); idle(1);
      put(16'h4B60); put(16'h4B0F); put(16'h4A00); idle(1);
    end

    cur_req = "R11";
    hi = 16'hF000; lo = 16'hE000;
    setcfg(mk(0, 0, 0, 2'd0, 2'd3));
    put(16'h0100); idle(1); expect_out(1'b0, "R11");
    put(16'hE800); put(16'hD000); idle(1); expect_out(1'b1, "R11");
    put(16'h8000); put(16'h7FF0); idle(1);

    cur_req = "R12";
    setcfg(mk(0, 1, 0, 2'd0, 2'd3)); idle(1); expect_out(1'b1, "R12");
    put(16'h7000); idle(1);
    setcfg(mk(0, 0, 0, 2'd0, 2'd3)); idle(2);

    // random mix against the model
    cur_req = "R3";
    hi = 16'h5000; lo = 16'h4B00;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      sv  = ($urandom_range(0, 2) != 0);
      smp = 16'h4000 + 16'($urandom_range(0, 16'h1800));
      rd  = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 39) == 0)
        cfg = mk($urandom_range(0, 15) == 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
    end
    idle(3);

    done = 1;
    report();
  end
endmodule